// File: doc/BRIEF.md
# Chained Receive Descriptor DMA Writer

This block takes received frames from a byte stream and stores them in memory buffers that software describes with a ring of four-word descriptors. It reads each descriptor through a single request/acknowledge memory port and uses it only if software has handed it over. It then writes the frame bytes into that descriptor's buffer and writes back a status word. The status word carries the frame length, the first-buffer and last-buffer marks and an error mark. The block then moves to the next descriptor. It finds that descriptor through the chained pointer, by stepping to the adjacent descriptor, or by wrapping to the ring base.

A frame larger than one buffer continues across several descriptors. If no descriptor is free in the middle of a frame, the block closes the current descriptor as the last one with an error, discards the rest of the frame and suspends. Software restarts a suspended engine, or starts an idle one after reset, by pulsing `poll`.

Descriptor word layout, at byte offsets 0, 4, 8 and 12 from the descriptor address:
- Word 0 (status): bit 31 is the ownership bit (1 means the engine may use it). Bits 29:16 hold the frame length. Bit 15 is the error summary. Bit 9 marks the first buffer of a frame. Bit 8 marks the last buffer.
- Word 1 (control): bits 11:0 give the buffer size in bytes. Bit 14 selects chained mode. Bit 15 marks the end of the ring.
- Word 2: the buffer byte address.
- Word 3: the next-descriptor address, used in chained mode.

States and transitions of the controller:
- IDLE goes to FETCH_OWN on `poll`, loading the ring base as the current descriptor.
- FETCH_OWN reads word 0. It goes to FETCH_CTL if bit 31 is set, and to SUSPEND otherwise.
- FETCH_CTL, FETCH_BUF and FETCH_NXT read words 1, 2 and 3 in turn, then go to RECV.
- RECV accepts one byte and goes to WDATA. If the buffer is full and another byte is waiting, it goes to PEEK instead.
- WDATA writes the byte. It returns to RECV, or goes to WB when the byte ended the frame.
- PEEK reads word 0 of the next descriptor and goes to WB.
- WB writes the status word. It goes to DROP after an overflow with no free descriptor, and to FETCH_OWN otherwise.
- DROP discards bytes until the end of the frame, then goes to FETCH_OWN.
- SUSPEND goes to FETCH_OWN on `poll`.

Top module: `rx_desc_dma`

## Requirements
- R1: After reset the block issues no memory request and holds `rx_ready` low until `poll` pulses. The first request then reads word 0 at `ring_base`.
- R2: A descriptor read with bit 31 of word 0 clear puts the block in suspend. In suspend it issues no memory request and accepts no byte until `poll` pulses. After `poll` it reads the same descriptor again.
- R3: Byte k of a buffer is written to buffer address + k with a single byte enable, `mem_be` bit = address[1:0], and never at an offset equal to or beyond the size in word 1 bits 11:0.
- R4: The status word is written to word 0 only after every data write for that buffer has been acknowledged. In it, bit 31 is cleared, bit 9 is first, bit 8 is last and bit 15 is error. Bits 29:16 hold the frame length when bit 8 is set and are zero otherwise. All other bits are zero.
- R5: A frame that fits in one buffer, including one that fills it exactly, gives a single status with first and last set and the exact length.
- R6: A frame larger than a buffer continues in the next owned descriptor. Only the descriptor with the first byte has bit 9 set, intermediate ones have bit 8 clear, and the final one has bit 8 set with the total frame length.
- R7: The next descriptor is chosen in this order. If word 1 bit 15 is set, it is `ring_base`. Otherwise, if bit 14 is set, it is word 3. Otherwise it is the current address + 16.
- R8: A frame whose last byte carries `rx_err` is closed with bit 15 set. A frame without it is closed with bit 15 clear.
- R9: When a buffer fills mid-frame and the next descriptor is not owned, the current descriptor is closed with bits 8 and 15 set and the byte count stored so far. The rest of the frame is consumed and discarded, and the block then suspends on that next descriptor.
- R10: A memory request keeps its address, direction, data and byte enables stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_base | input | ADDR_W | Address of the first descriptor of the ring |
| poll | input | 1 | Start/resume strobe, acted on in IDLE and SUSPEND |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Byte ends the frame |
| rx_err | input | 1 | Frame ended with an error (with rx_last) |
| rx_ready | output | 1 | Byte accepted when high with rx_valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 32 | Write data (byte writes replicate the byte) |
| mem_be | output | 4 | Byte enables |
| mem_ack | input | 1 | Request completed; read data valid this cycle |
| mem_rdata | input | 32 | Read data |

## Verification
The bench targets these corner cases:
- A frame that fills a buffer exactly. A design with an off-by-one here would either open an extra descriptor or write past the buffer.
- A frame spanning an unchained descriptor into a chained one, and an end-of-ring descriptor whose word 3 holds garbage. A design with the wrong next-address priority would write the next frame into the wrong place.
- An overflow into an unowned descriptor. A design that wrote back before checking the next descriptor would leave the last and error marks clear, and its leftover bytes would spill into the following frame.
- The quiet window in suspend, where a design that polled on its own would show memory traffic.
- Memory acknowledges with random latency. These expose a status word written before its data, or a request that moves before it is acknowledged.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
    localparam int unsigned OWN_B      = 31;
    localparam int unsigned LEN_LO     = 16;
    localparam int unsigned ES_B       = 15;
    localparam int unsigned FS_B       = 9;
    localparam int unsigned LS_B       = 8;
    localparam int unsigned CHAIN_B    = 14;
    localparam int unsigned EOR_B      = 15;
    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned DESC_WORDS = 4;
    localparam int unsigned DESC_BYTES = WORD_BYTES * DESC_WORDS;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH_OWN,
        ST_FETCH_CTL,
        ST_FETCH_BUF,
        ST_FETCH_NXT,
        ST_RECV,
        ST_WDATA,
        ST_PEEK,
        ST_WB,
        ST_DROP,
        ST_SUSPEND
    } dma_state_e;
endpackage

// File: rtl/rxdma_desc_cache.sv
module rxdma_desc_cache
    import rxdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned SIZE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_ctl,
    input  logic              ld_buf,
    input  logic              ld_nxt,
    input  logic [31:0]       rdata,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] ring_base,
    output logic [SIZE_W-1:0] buf_size,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [ADDR_W-1:0] next_addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

    logic              chain_q;
    logic              eor_q;
    logic [ADDR_W-1:0] link_q;
    logic              unused_bits;

    assign unused_bits = ^{rdata[31:16], rdata[13:SIZE_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_size <= '0;
            chain_q  <= 1'b0;
            eor_q    <= 1'b0;
            buf_addr <= '0;
            link_q   <= '0;
        end else begin
            if (ld_ctl) begin
                buf_size <= rdata[SIZE_W-1:0];
                chain_q  <= rdata[CHAIN_B];
                eor_q    <= rdata[EOR_B];
            end
            if (ld_buf) buf_addr <= rdata[ADDR_W-1:0];
            if (ld_nxt) link_q   <= rdata[ADDR_W-1:0];
        end
    end

    // End of ring overrides the chain pointer; unchained steps to the adjacent descriptor.
    always_comb begin
        if (eor_q)        next_addr = ring_base;
        else if (chain_q) next_addr = link_q;
        else              next_addr = cur_addr + STEP;
    end
endmodule

// File: rtl/rxdma_status_pack.sv
module rxdma_status_pack
    import rxdma_pkg::*;
#(
    parameter int unsigned FLEN_W = 14
) (
    input  logic              fs,
    input  logic              ls,
    input  logic              es,
    input  logic [FLEN_W-1:0] flen,
    output logic [31:0]       word
);
    always_comb begin
        word             = '0;
        word[FS_B]       = fs;
        word[LS_B]       = ls;
        word[ES_B]       = es;
        if (ls) word[LEN_LO +: FLEN_W] = flen;
    end
endmodule

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl
    import rxdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned SIZE_W = 12,
    parameter int unsigned FLEN_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    input  logic              s_err,
    output logic              s_ready,
    output logic              m_req,
    output logic              m_we,
    output logic [ADDR_W-1:0] m_addr,
    output logic [31:0]       m_wdata,
    output logic [3:0]        m_be,
    input  logic              m_ack,
    input  logic              own_bit,
    input  logic [SIZE_W-1:0] buf_size,
    input  logic [ADDR_W-1:0] buf_addr,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic [31:0]       status_word,
    output logic              ld_ctl,
    output logic              ld_buf,
    output logic              ld_nxt,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              st_fs,
    output logic              st_ls,
    output logic              st_es,
    output logic [FLEN_W-1:0] st_flen
);
    localparam logic [ADDR_W-1:0] OFS_CTL = ADDR_W'(1 * WORD_BYTES);
    localparam logic [ADDR_W-1:0] OFS_BUF = ADDR_W'(2 * WORD_BYTES);
    localparam logic [ADDR_W-1:0] OFS_NXT = ADDR_W'(3 * WORD_BYTES);

    dma_state_e        state, state_nx;
    logic [SIZE_W-1:0] cnt;
    logic              in_frame;
    logic [7:0]        lat_byte;
    logic              lat_last;
    logic              lat_err;
    logic              wb_drop;
    logic              buf_full;

    assign buf_full = (cnt == buf_size);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (poll) state_nx = ST_FETCH_OWN;
            ST_SUSPEND:   if (poll) state_nx = ST_FETCH_OWN;
            ST_FETCH_OWN: if (m_ack) state_nx = own_bit ? ST_FETCH_CTL : ST_SUSPEND;
            ST_FETCH_CTL: if (m_ack) state_nx = ST_FETCH_BUF;
            ST_FETCH_BUF: if (m_ack) state_nx = ST_FETCH_NXT;
            ST_FETCH_NXT: if (m_ack) state_nx = ST_RECV;
            ST_RECV:      if (s_valid) state_nx = buf_full ? ST_PEEK : ST_WDATA;
            ST_WDATA:     if (m_ack) state_nx = lat_last ? ST_WB : ST_RECV;
            ST_PEEK:      if (m_ack) state_nx = ST_WB;
            ST_WB:        if (m_ack) state_nx = wb_drop ? ST_DROP : ST_FETCH_OWN;
            ST_DROP:      if (s_valid && s_last) state_nx = ST_FETCH_OWN;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cnt      <= '0;
            in_frame <= 1'b0;
            lat_byte <= '0;
            lat_last <= 1'b0;
            lat_err  <= 1'b0;
            st_fs    <= 1'b0;
            st_ls    <= 1'b0;
            st_es    <= 1'b0;
            wb_drop  <= 1'b0;
            st_flen  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (poll) cur_addr <= ring_base;
                ST_FETCH_OWN: if (m_ack && own_bit) begin
                    cnt   <= '0;
                    st_fs <= 1'b0;
                    st_ls <= 1'b0;
                    st_es <= 1'b0;
                end
                ST_RECV: if (s_valid && !buf_full) begin
                    lat_byte <= s_data;
                    lat_last <= s_last;
                    lat_err  <= s_err;
                    if (!in_frame) begin
                        in_frame <= 1'b1;
                        st_fs    <= 1'b1;
                        st_flen  <= '0;
                    end
                end
                ST_WDATA: if (m_ack) begin
                    cnt     <= cnt + 1'b1;
                    st_flen <= st_flen + 1'b1;
                    if (lat_last) begin
                        st_ls   <= 1'b1;
                        st_es   <= lat_err;
                        wb_drop <= 1'b0;
                    end
                end
                ST_PEEK: if (m_ack) begin
                    st_ls   <= !own_bit;
                    st_es   <= !own_bit;
                    wb_drop <= !own_bit;
                end
                ST_WB: if (m_ack) begin
                    cur_addr <= next_addr;
                    if (st_ls) in_frame <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        m_req   = 1'b0;
        m_we    = 1'b0;
        m_addr  = cur_addr;
        m_wdata = '0;
        m_be    = 4'hF;
        s_ready = 1'b0;
        unique case (state)
            ST_FETCH_OWN: m_req = 1'b1;
            ST_FETCH_CTL: begin m_req = 1'b1; m_addr = cur_addr + OFS_CTL; end
            ST_FETCH_BUF: begin m_req = 1'b1; m_addr = cur_addr + OFS_BUF; end
            ST_FETCH_NXT: begin m_req = 1'b1; m_addr = cur_addr + OFS_NXT; end
            ST_PEEK:      begin m_req = 1'b1; m_addr = next_addr; end
            ST_WDATA: begin
                m_req   = 1'b1;
                m_we    = 1'b1;
                m_addr  = buf_addr + ADDR_W'(cnt);
                m_wdata = {4{lat_byte}};
                m_be    = 4'b0001 << m_addr[1:0];
            end
            ST_WB: begin
                m_req   = 1'b1;
                m_we    = 1'b1;
                m_wdata = status_word;
            end
            ST_RECV:  s_ready = !buf_full;
            ST_DROP:  s_ready = 1'b1;
            default: ;
        endcase
    end

    assign ld_ctl = (state == ST_FETCH_CTL) && m_ack;
    assign ld_buf = (state == ST_FETCH_BUF) && m_ack;
    assign ld_nxt = (state == ST_FETCH_NXT) && m_ack;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!m_req && !s_ready)); // R1
    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSPEND && !poll) |=> (state == ST_SUSPEND && !m_req && !s_ready)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA) |-> (cnt < buf_size)); // R3
    AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_we && m_be == 4'hF) |-> !m_wdata[OWN_B]); // R4
    AST_DROP_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WB && wb_drop) |-> (m_wdata[LS_B] && m_wdata[ES_B])); // R9
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we)
                               && $stable(m_wdata) && $stable(m_be))); // R10
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
    import rxdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned SIZE_W = 12,
    parameter int unsigned FLEN_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              poll,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_err,
    output logic              rx_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    logic              ld_ctl, ld_buf, ld_nxt;
    logic [ADDR_W-1:0] cur_addr, buf_addr, next_addr;
    logic [SIZE_W-1:0] buf_size;
    logic              st_fs, st_ls, st_es;
    logic [FLEN_W-1:0] st_flen;
    logic [31:0]       status_word;

    rxdma_desc_cache #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_ctl    (ld_ctl),
        .ld_buf    (ld_buf),
        .ld_nxt    (ld_nxt),
        .rdata     (mem_rdata),
        .cur_addr  (cur_addr),
        .ring_base (ring_base),
        .buf_size  (buf_size),
        .buf_addr  (buf_addr),
        .next_addr (next_addr)
    );

    rxdma_status_pack #(.FLEN_W(FLEN_W)) u_pack (
        .fs   (st_fs),
        .ls   (st_ls),
        .es   (st_es),
        .flen (st_flen),
        .word (status_word)
    );

    rxdma_ctrl #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .FLEN_W(FLEN_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .poll        (poll),
        .ring_base   (ring_base),
        .s_valid     (rx_valid),
        .s_data      (rx_data),
        .s_last      (rx_last),
        .s_err       (rx_err),
        .s_ready     (rx_ready),
        .m_req       (mem_req),
        .m_we        (mem_we),
        .m_addr      (mem_addr),
        .m_wdata     (mem_wdata),
        .m_be        (mem_be),
        .m_ack       (mem_ack),
        .own_bit     (mem_rdata[OWN_B]),
        .buf_size    (buf_size),
        .buf_addr    (buf_addr),
        .next_addr   (next_addr),
        .status_word (status_word),
        .ld_ctl      (ld_ctl),
        .ld_buf      (ld_buf),
        .ld_nxt      (ld_nxt),
        .cur_addr    (cur_addr),
        .st_fs       (st_fs),
        .st_ls       (st_ls),
        .st_es       (st_es),
        .st_flen     (st_flen)
    );
endmodule

// File: tb/rx_desc_dma_bench.sv
module rx_desc_dma_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ring_base = 32'h0;
    logic        poll = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        rx_err = 1'b0;
    logic        rx_ready;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;

    logic [31:0] mem   [MEM_WORDS];
    logic [31:0] exp_m [MEM_WORDS];

    int  vectors = 0;
    int  fails   = 0;
    int  req_cnt = 0;
    int  hold_viol = 0;
    logic ack_q = 1'b0;
    int  wait_c = 0;

    int  d_at   [4] = '{32'h000, 32'h100, 32'h110, 32'h040};
    int  d_buf  [4] = '{32'h400, 32'h602, 32'h800, 32'hA01};
    int  d_size [4] = '{64, 20, 37, 100};
    bit  owned  [4];
    int  mi = 0;
    int  touched [4];
    int  tcount = 0;
    bit  dropped = 0;
    logic [7:0] fb [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_desc_dma u_rx_desc_dma (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .poll(poll),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
        .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    assign mem_ack   = ack_q;
    assign mem_rdata = mem[mem_addr[11:2]];

    // Memory model with random acknowledge latency
    logic        p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
    logic [31:0] p_addr = '0, p_wdata = '0;
    logic [3:0]  p_be = '0;
    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_req) req_cnt++;
            if (p_req && !p_ack && (!mem_req || mem_addr != p_addr || mem_we != p_we
                || mem_wdata != p_wdata || mem_be != p_be)) hold_viol++;
        end
        p_req = mem_req; p_ack = mem_ack; p_we = mem_we;
        p_addr = mem_addr; p_wdata = mem_wdata; p_be = mem_be;
        if (!rst_n) begin
            ack_q  <= 1'b0;
            wait_c <= 0;
        end else if (ack_q) begin
            ack_q <= 1'b0;
            if (mem_we) begin
                for (int l = 0; l < 4; l++)
                    if (mem_be[l]) mem[mem_addr[11:2]][8*l +: 8] = mem_wdata[8*l +: 8];
            end
        end else if (mem_req) begin
            if (wait_c == 0) begin
                ack_q  <= 1'b1;
                wait_c <= int'($urandom % 3);
            end else begin
                wait_c <= wait_c - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
        summary();
    end

    function automatic int nxt(input int d);
        return (d + 1) % 4;
    endfunction

    function automatic logic [31:0] mk_status(input bit fs, input bit ls, input bit es, input int len);
        logic [13:0] l;
        l = ls ? 14'(len) : 14'd0;
        return {2'b00, l, es, 5'b0, fs, ls, 8'b0};
    endfunction

    task automatic put_byte(input int a, input logic [7:0] b);
        exp_m[a >> 2][8*(a % 4) +: 8] = b;
    endtask

    task automatic arm(input int d);
        mem[d_at[d] >> 2]   = 32'h8000_0000;
        exp_m[d_at[d] >> 2] = 32'h8000_0000;
        owned[d] = 1'b1;
    endtask

    // Bench reference: walk the ring as the requirements describe
    task automatic model_frame(input int len, input bit err);
        int rem, tot, k, d;
        bit first;
        rem = len; tot = 0; k = 0; first = 1'b1;
        tcount = 0; dropped = 1'b0;
        forever begin
            d = mi;
            touched[tcount] = d;
            tcount++;
            owned[d] = 1'b0;
            if (rem <= d_size[d]) begin
                for (int b = 0; b < rem; b++) put_byte(d_buf[d] + b, fb[k + b]);
                exp_m[d_at[d] >> 2] = mk_status(first, 1'b1, err, len);
                mi = nxt(d);
                return;
            end
            for (int b = 0; b < d_size[d]; b++) put_byte(d_buf[d] + b, fb[k + b]);
            k += d_size[d]; rem -= d_size[d]; tot += d_size[d];
            mi = nxt(d);
            if (owned[mi]) begin
                exp_m[d_at[d] >> 2] = mk_status(first, 1'b0, 1'b0, 0);
                first = 1'b0;
            end else begin
                exp_m[d_at[d] >> 2] = mk_status(first, 1'b1, 1'b1, tot);
                dropped = 1'b1;
                return;
            end
        end
    endtask

    task automatic send_frame(input int len, input bit err);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = fb[i];
            rx_last  = (i == len - 1);
            rx_err   = err && (i == len - 1);
            while (!rx_ready) @(negedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    endtask

    task automatic do_poll();
        @(negedge clk); poll = 1'b1;
        @(negedge clk); poll = 1'b0;
    endtask

    task automatic run_frame(input int len, input bit err, input string tag);
        int d;
        for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
        model_frame(len, err);
        send_frame(len, err);
        repeat (40) @(negedge clk);
        for (int t = 0; t < tcount; t++) begin
            d = touched[t];
            chk(mem[d_at[d] >> 2] == exp_m[d_at[d] >> 2], tag,
                mem[d_at[d] >> 2], exp_m[d_at[d] >> 2]);
            for (int a = d_buf[d] >> 2; a <= (d_buf[d] + d_size[d] - 1) >> 2; a++)
                chk(mem[a] == exp_m[a], "R3 buffer bytes", mem[a], exp_m[a]);
        end
    endtask

    task automatic rearm_touched();
        for (int t = 0; t < tcount; t++) arm(touched[t]);
        do_poll();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int base_req, len;
        bit err, quiet;
        void'($urandom(32'd2024));
        for (int i = 0; i < MEM_WORDS; i++) begin mem[i] = '0; exp_m[i] = '0; end
        // D0 chained to D1; D1 unchained (next = +16 = D2); D2 chained to D3; D3 end of ring
        for (int d = 0; d < 4; d++) begin
            logic [31:0] ctl, lnk;
            case (d)
                0: begin ctl = 32'h4000 | 32'(d_size[0]); lnk = 32'h100; end
                1: begin ctl = 32'(d_size[1]);            lnk = 32'hFFC; end
                2: begin ctl = 32'h4000 | 32'(d_size[2]); lnk = 32'h040; end
                default: begin ctl = 32'hC000 | 32'(d_size[3]); lnk = 32'h3F0; end
            endcase
            mem[(d_at[d] >> 2) + 1] = ctl;        exp_m[(d_at[d] >> 2) + 1] = ctl;
            mem[(d_at[d] >> 2) + 2] = d_buf[d];   exp_m[(d_at[d] >> 2) + 2] = d_buf[d];
            mem[(d_at[d] >> 2) + 3] = lnk;        exp_m[(d_at[d] >> 2) + 3] = lnk;
            arm(d);
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        base_req = req_cnt;
        quiet = 1'b1;
        repeat (10) begin @(negedge clk); if (rx_ready) quiet = 1'b0; end
        chk(req_cnt == base_req, "R1 no request before poll", req_cnt - base_req, 0);
        chk(quiet, "R1 rx_ready low before poll", {31'b0, !quiet}, 0);
        @(negedge clk); poll = 1'b1;
        @(negedge clk); poll = 1'b0;
        chk(mem_req && !mem_we && mem_addr == ring_base, "R1 first read at ring base",
            mem_addr, ring_base);

        run_frame(64, 1'b0, "R5 exact fill"); rearm_touched();
        run_frame(50, 1'b0, "R6 R7 span through unchained"); rearm_touched();
        run_frame(5, 1'b1, "R8 error frame"); rearm_touched();
        run_frame(1, 1'b0, "R7 end-of-ring wrap"); rearm_touched();

        // Overflow into an unowned descriptor
        mem[d_at[2] >> 2] = '0; exp_m[d_at[2] >> 2] = '0; owned[2] = 1'b0;
        run_frame(40, 1'b0, "R9 drop closes current");
        chk(dropped, "R9 model expects drop", {31'b0, dropped}, 1);
        for (int t = 0; t < tcount; t++) arm(touched[t]);
        base_req = req_cnt;
        quiet = 1'b1;
        repeat (30) begin @(negedge clk); if (rx_ready) quiet = 1'b0; end
        chk(req_cnt == base_req, "R2 suspend issues no request", req_cnt - base_req, 0);
        chk(quiet, "R2 suspend accepts no byte", {31'b0, !quiet}, 0);
        arm(2);
        do_poll();
        repeat (4) @(negedge clk);
        run_frame(30, 1'b0, "R2 resume at same descriptor"); rearm_touched();

        for (int n = 0; n < 24; n++) begin
            len = 1 + int'($urandom % 150);
            err = ($urandom % 4) == 0;
            run_frame(len, err, "R4 R6 R8 random frame");
            rearm_touched();
        end

        chk(hold_viol == 0, "R10 request held until ack", hold_viol, 0);
        summary();
    end
endmodule